// File: doc/BRIEF.md
# Clock Source Selection Controller

This block chooses the system clock for a small microcontroller from three sources: the main crystal clock, a low-frequency internal oscillator, and a PLL that multiplies the main clock. Software drives it through a narrow register write port. A control word holds the source and enable bits. A separate word holds the PLL multiplier, which can be written once. A third word clears the sticky flags. The analog oscillators, the PLL and the glitch-free clock mux are outside this block. Here they appear only as enable and select outputs.

The controller enforces the rules of safe clock switching. The PLL may drive the system only after it has been enabled for a settling time. While the PLL drives the system, two wait states must be in force. A wait request or a stop request is refused while the PLL is the system clock. A stop request is also refused while the PLL is enabled. Any broken rule is rejected and latches a violation flag. If the main oscillator stops while detection is armed, the block switches to the internal oscillator on its own and raises an interrupt.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset, ioc_en, pll_en, wait2, failover_irq, viol, wait_ack and stop_ack are 0. pll_mult is 3'b000 and clk_sel is 2'd0 (main clock).
- R2: clk_sel encodes the source as 0 for main, 1 for internal oscillator and 2 for PLL. Control word (wr_addr 0) bit 0 set drives ioc_en to 1 and clk_sel to 1, and it takes priority over the PLL select. Clearing the bit returns to the main clock unless the PLL is selected.
- R3: Control bit 1 is the stop-detect enable and control bit 2 is the stop-interrupt enable. When both are 1, a rising edge on osc_stop_i sets bit 0 and clears the PLL select on the next clock, so clk_sel becomes 1 and failover_irq becomes 1. When either bit is 0, the edge has no effect.
- R4: failover_irq stays set until a write to wr_addr 2 with bit 0 = 1. An osc_stop_i level that stays high does not set it again.
- R5: Control bit 3 drives pll_en. A settling counter runs while pll_en is 1, saturates at SETTLE_CYCLES, and clears while pll_en is 0.
- R6: A control write with bit 4 = 1 selects the PLL only if all of these hold: pll_en was already 1, the counter has reached SETTLE_CYCLES, and the same write keeps bit 3 = 1 and bit 5 (wait2, two wait states) = 1. Otherwise the PLL select is cleared and viol is set.
- R7: The multiplier word (wr_addr 1, bits 2:0) accepts codes 3'b001 (x2), 3'b010 (x4) and 3'b011 (x6). The first valid write locks pll_mult. Every later write is ignored and does not set viol.
- R8: Before the lock, a write of any other code leaves pll_mult unchanged, does not lock it, and sets viol.
- R9: A wait_req pulse gives a wait_ack pulse on the next clock when the PLL is not selected. Otherwise it is refused and viol is set.
- R10: A stop_req pulse gives a stop_ack pulse on the next clock only when the PLL is neither selected nor enabled. Otherwise it is refused and viol is set.
- R11: viol is sticky and is cleared by a write to wr_addr 2 with bit 1 = 1. A new violation in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word select: 0 control, 1 multiplier, 2 flag clear |
| wr_data | input | 6 | Write data |
| osc_stop_i | input | 1 | Main oscillation stop detector, synchronous to clk |
| wait_req | input | 1 | Wait mode request pulse |
| stop_req | input | 1 | Stop mode request pulse |
| ioc_en | output | 1 | Internal oscillator enable |
| pll_en | output | 1 | PLL enable |
| pll_mult | output | 3 | Locked PLL multiplier code |
| clk_sel | output | 2 | Clock mux select |
| wait2 | output | 1 | Two wait states selected |
| wait_ack | output | 1 | Wait request accepted |
| stop_ack | output | 1 | Stop request accepted |
| failover_irq | output | 1 | Sticky fail-over interrupt |
| viol | output | 1 | Sticky rule-violation flag |

## Verification
The assertions assume that osc_stop_i, wait_req and stop_req are already synchronous to clk, and that the two requests are single-cycle pulses. If these assumptions do not hold, the edge detection and the one-cycle acknowledge relation lose their meaning. The bench changes every input on the falling clock edge and holds each request for exactly one cycle. It raises the stop detector once and then holds it high, to show that a level does not repeat the event. The settling sweep applies the PLL select write at every delay from one cycle up to two cycles past the settling count.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  localparam int CTRL_W = 6;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_INT  = 2'd1,
    SRC_PLL  = 2'd2
  } src_e;

  // bit 5 .. bit 0
  typedef struct packed {
    logic wait2;
    logic pll_sel;
    logic pll_en;
    logic det_ie;
    logic det_en;
    logic int_sel;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MULT = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  function automatic logic mult_code_ok(input logic [2:0] code);
    return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
  endfunction

endpackage

// File: rtl/clk_settle_timer.sv
module clk_settle_timer #(
  parameter int unsigned SETTLE = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic settled
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LIM = CW'(SETTLE);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_le;

  always_comb begin
    cnt_le = run || (cnt_q != '0);
    if (!run)             cnt_d = '0;
    else if (cnt_q == LIM) cnt_d = cnt_q;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_le) cnt_q <= cnt_d;
  end

  assign settled = (cnt_q == LIM);
endmodule

// File: rtl/clk_stop_monitor.sv
module clk_stop_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic arm,
  output logic fo_event
);
  logic stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= 1'b0;
    else        stop_q <= stop_i;
  end

  assign fo_event = arm && stop_i && !stop_q;
endmodule

// File: rtl/clk_lp_gate.sv
module clk_lp_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_req,
  input  logic stop_req,
  input  logic pll_sel,
  input  logic pll_on,
  output logic wait_ack,
  output logic stop_ack,
  output logic refuse
);
  logic wait_ok, stop_ok;

  always_comb begin
    wait_ok = wait_req && !pll_sel;
    stop_ok = stop_req && !pll_sel && !pll_on;
    refuse  = (wait_req && !wait_ok) || (stop_req && !stop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_ack <= 1'b0;
      stop_ack <= 1'b0;
    end else begin
      wait_ack <= wait_ok;
      stop_ack <= stop_ok;
    end
  end
endmodule

// File: rtl/clk_ctrl_regs.sv
module clk_ctrl_regs
  import clk_src_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              settled,
  input  logic              fo_event,
  input  logic              lp_refuse,
  output ctrl_t             ctrl_q,
  output logic [2:0]        mult_q,
  output logic              irq_q,
  output logic              viol_q
);
  ctrl_t      ctrl_d, req;
  logic [2:0] mult_d;
  logic       lock_q, lock_d;
  logic       irq_d, viol_d;
  logic       ctrl_le, mult_le, set_viol;

  always_comb begin
    ctrl_d   = ctrl_q;
    mult_d   = mult_q;
    lock_d   = lock_q;
    irq_d    = irq_q;
    viol_d   = viol_q;
    set_viol = 1'b0;
    ctrl_le  = 1'b0;
    mult_le  = 1'b0;
    req      = ctrl_t'(wr_data);

    if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          ctrl_le = 1'b1;
          ctrl_d  = req;
          if (req.pll_sel &&
              !(ctrl_q.pll_en && req.pll_en && settled && req.wait2)) begin
            ctrl_d.pll_sel = 1'b0;
            set_viol       = 1'b1;
          end
        end
        ADDR_MULT: begin
          if (!lock_q) begin
            if (mult_code_ok(wr_data[2:0])) begin
              mult_le = 1'b1;
              mult_d  = wr_data[2:0];
              lock_d  = 1'b1;
            end else begin
              set_viol = 1'b1;
            end
          end
        end
        ADDR_FLAG: begin
          if (wr_data[0]) irq_d  = 1'b0;
          if (wr_data[1]) viol_d = 1'b0;
        end
        default: ;
      endcase
    end

    if (fo_event) begin
      ctrl_le        = 1'b1;
      ctrl_d.int_sel = 1'b1;
      ctrl_d.pll_sel = 1'b0;
      irq_d          = 1'b1;
    end

    if (set_viol || lp_refuse) viol_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mult_q <= '0;
      lock_q <= 1'b0;
      irq_q  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      if (ctrl_le) ctrl_q <= ctrl_d;
      if (mult_le) begin
        mult_q <= mult_d;
        lock_q <= lock_d;
      end
      irq_q  <= irq_d;
      viol_q <= viol_d;
    end
  end
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [5:0] wr_data,
  input  logic       osc_stop_i,
  input  logic       wait_req,
  input  logic       stop_req,
  output logic       ioc_en,
  output logic       pll_en,
  output logic [2:0] pll_mult,
  output logic [1:0] clk_sel,
  output logic       wait2,
  output logic       wait_ack,
  output logic       stop_ack,
  output logic       failover_irq,
  output logic       viol
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  ctrl_t      ctrl_q;
  logic       settled, fo_event, lp_refuse;
  src_e       src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  clk_settle_timer #(.SETTLE(SETTLE_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (ctrl_q.pll_en),
    .settled (settled)
  );

  clk_stop_monitor u_mon (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .stop_i   (osc_stop_i),
    .arm      (ctrl_q.det_en && ctrl_q.det_ie),
    .fo_event (fo_event)
  );

  clk_lp_gate u_lp (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wait_req (wait_req),
    .stop_req (stop_req),
    .pll_sel  (ctrl_q.pll_sel),
    .pll_on   (ctrl_q.pll_en),
    .wait_ack (wait_ack),
    .stop_ack (stop_ack),
    .refuse   (lp_refuse)
  );

  clk_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .settled   (settled),
    .fo_event  (fo_event),
    .lp_refuse (lp_refuse),
    .ctrl_q    (ctrl_q),
    .mult_q    (pll_mult),
    .irq_q     (failover_irq),
    .viol_q    (viol)
  );

  always_comb begin
    if (ctrl_q.int_sel)      src = SRC_INT;
    else if (ctrl_q.pll_sel) src = SRC_PLL;
    else                     src = SRC_MAIN;
  end

  assign clk_sel = src;
  assign ioc_en  = ctrl_q.int_sel;
  assign pll_en  = ctrl_q.pll_en;
  assign wait2   = ctrl_q.wait2;
endmodule

// File: rtl/clk_src_ctrl_chk.sv
module clk_src_ctrl_chk #(
  parameter int unsigned SETTLE = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ioc_en,
  input logic       pll_en,
  input logic [2:0] pll_mult,
  input logic [1:0] clk_sel,
  input logic       wait2,
  input logic       wait_ack,
  input logic       stop_ack,
  input logic       stop_req,
  input logic       failover_irq,
  input logic       viol,
  input logic       fo_event
);
  logic [31:0] on_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 on_cnt <= '0;
    else if (!pll_en)           on_cnt <= '0;
    else if (on_cnt < SETTLE)   on_cnt <= on_cnt + 1;
  end

  assert_int_drives_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd1) |-> ioc_en);

  assert_failover_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fo_event |=> (clk_sel == 2'd1 && ioc_en && failover_irq));

  assert_settle_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd2) |-> (on_cnt >= SETTLE));

  assert_pll_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd2) |-> pll_en);

  assert_pll_two_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd2) |-> wait2);

  assert_mult_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_mult != 3'd0) |=> $stable(pll_mult));

  assert_mult_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_mult != 3'd0) |-> (pll_mult <= 3'd3));

  assert_wait_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_ack |-> ($past(clk_sel) != 2'd2));

  assert_stop_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ack |-> !$past(pll_en));

  assert_stop_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && pll_en) |=> (viol && !stop_ack));
endmodule

bind clk_src_ctrl clk_src_ctrl_chk #(.SETTLE(SETTLE_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ioc_en       (ioc_en),
  .pll_en       (pll_en),
  .pll_mult     (pll_mult),
  .clk_sel      (clk_sel),
  .wait2        (wait2),
  .wait_ack     (wait_ack),
  .stop_ack     (stop_ack),
  .stop_req     (stop_req),
  .failover_irq (failover_irq),
  .viol         (viol),
  .fo_event     (fo_event)
);

// File: tb/clk_src_ctrl_test.sv
`timescale 1ns/1ps
module clk_src_ctrl_test;
  localparam int S = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [5:0] wr_data;
  logic       osc_stop_i, wait_req, stop_req;
  logic       ioc_en, pll_en, wait2, wait_ack, stop_ack, failover_irq, viol;
  logic [2:0] pll_mult;
  logic [1:0] clk_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  clk_src_ctrl #(.SETTLE_CYCLES(S)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .osc_stop_i(osc_stop_i), .wait_req(wait_req), .stop_req(stop_req),
    .ioc_en(ioc_en), .pll_en(pll_en), .pll_mult(pll_mult), .clk_sel(clk_sel),
    .wait2(wait2), .wait_ack(wait_ack), .stop_ack(stop_ack),
    .failover_irq(failover_irq), .viol(viol)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lp(input logic w, input logic s);
    @(negedge clk);
    wait_req = w; stop_req = s;
    @(negedge clk);
    wait_req = 1'b0; stop_req = 1'b0;
  endtask

  task automatic pll_ready(input logic [5:0] extra);
    wr(2'd0, 6'h20 | extra);
    wr(2'd2, 6'h03);
    wr(2'd0, 6'h28 | extra);
    repeat (S) @(negedge clk);
    wr(2'd0, 6'h38 | extra);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    osc_stop_i = 1'b0; wait_req = 1'b0; stop_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 ioc_en", ioc_en, 0);
    chk("R1 pll_en", pll_en, 0);
    chk("R1 clk_sel", clk_sel, 0);
    chk("R1 pll_mult", pll_mult, 0);
    chk("R1 flags", {failover_irq, viol, wait2, wait_ack, stop_ack}, 0);

    // R2 internal oscillator select
    wr(2'd0, 6'h01);
    chk("R2 ioc_en", ioc_en, 1);
    chk("R2 clk_sel int", clk_sel, 1);
    wr(2'd0, 6'h00);
    chk("R2 clk_sel main", clk_sel, 0);

    // R8 invalid multiplier codes before lock
    for (int c = 0; c < 8; c++) begin
      if (c >= 1 && c <= 3) continue;
      wr(2'd1, 6'(c));
      chk("R8 viol on bad code", viol, 1);
      chk("R8 mult unchanged", pll_mult, 0);
      wr(2'd2, 6'h02);
      chk("R11 viol cleared", viol, 0);
    end
    // R7 first valid write locks, later ones ignored
    wr(2'd1, 6'h02);
    chk("R7 mult stored", pll_mult, 2);
    for (int c = 0; c < 8; c++) begin
      wr(2'd1, 6'(c));
      chk("R7 mult locked", pll_mult, 2);
      chk("R7 no viol after lock", viol, 0);
    end

    // R5 R6 settling sweep
    for (int d = 1; d <= S + 2; d++) begin
      wr(2'd0, 6'h20);
      wr(2'd2, 6'h02);
      wr(2'd0, 6'h28);
      chk("R5 pll_en on", pll_en, 1);
      repeat (d - 1) @(negedge clk);
      wr(2'd0, 6'h38);
      chk("R6 select vs settle", clk_sel, (d >= S) ? 2 : 0);
      chk("R6 viol vs settle", viol, (d >= S) ? 0 : 1);
    end
    // R6 one wait state with PLL selected is rejected
    wr(2'd2, 6'h02);
    wr(2'd0, 6'h18);
    chk("R6 wait2 missing clk_sel", clk_sel, 0);
    chk("R6 wait2 missing viol", viol, 1);
    // R6 select while disabling
    pll_ready(6'h00);
    chk("R6 reselect", clk_sel, 2);
    wr(2'd2, 6'h02);
    wr(2'd0, 6'h30);
    chk("R6 select with pll off", clk_sel, 0);
    chk("R6 select with pll off viol", viol, 1);
    chk("R5 pll_en off", pll_en, 0);
    // R2 internal overrides PLL select
    pll_ready(6'h00);
    wr(2'd0, 6'h39);
    chk("R2 int over pll", clk_sel, 1);

    // R9 R10 low-power requests
    pll_ready(6'h00);
    wr(2'd2, 6'h02);
    lp(1'b1, 1'b0);
    chk("R9 wait refused ack", wait_ack, 0);
    chk("R9 wait refused viol", viol, 1);
    wr(2'd2, 6'h02);
    lp(1'b0, 1'b1);
    chk("R10 stop refused sel ack", stop_ack, 0);
    chk("R10 stop refused sel viol", viol, 1);
    wr(2'd0, 6'h28);
    wr(2'd2, 6'h02);
    lp(1'b1, 1'b0);
    chk("R9 wait accepted", wait_ack, 1);
    chk("R9 wait no viol", viol, 0);
    lp(1'b0, 1'b1);
    chk("R10 stop refused en ack", stop_ack, 0);
    chk("R10 stop refused en viol", viol, 1);
    wr(2'd0, 6'h20);
    wr(2'd2, 6'h02);
    lp(1'b0, 1'b1);
    chk("R10 stop accepted", stop_ack, 1);
    chk("R10 stop no viol", viol, 0);
    @(negedge clk);
    chk("R10 ack one cycle", stop_ack, 0);

    // R11 set wins over clear
    wr(2'd0, 6'h28);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 6'h02; stop_req = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; stop_req = 1'b0;
    chk("R11 set over clear", viol, 1);
    wr(2'd2, 6'h02);

    // R3 R4 fail-over
    pll_ready(6'h06);
    chk("R3 pll before stop", clk_sel, 2);
    @(negedge clk); osc_stop_i = 1'b1;
    @(negedge clk);
    chk("R3 failover clk_sel", clk_sel, 1);
    chk("R3 failover ioc_en", ioc_en, 1);
    chk("R3 failover irq", failover_irq, 1);
    repeat (3) @(negedge clk);
    chk("R4 irq sticky", failover_irq, 1);
    wr(2'd2, 6'h01);
    chk("R4 irq cleared", failover_irq, 0);
    repeat (2) @(negedge clk);
    chk("R4 level does not re-fire", failover_irq, 0);
    osc_stop_i = 1'b0;
    wr(2'd0, 6'h02);
    @(negedge clk); osc_stop_i = 1'b1;
    @(negedge clk);
    chk("R3 disarmed clk_sel", clk_sel, 0);
    chk("R3 disarmed irq", failover_irq, 0);
    osc_stop_i = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule